// File: doc/BRIEF.md
# Performance-State Request Arbiter

This block sits between software and the clock/voltage control of one power domain. Software writes a requested performance state; state 0 is the fastest, highest-voltage operating point, and each larger index is the next slower point down to the slowest point at index `NUM_STATES-1`. The block decides whether the request is granted. A granted request does not take effect at once. It stays pending for a number of microsecond ticks, and that latency depends on how recently the previous change completed.

Two hardware limits override software. While the over-temperature flag is high, the granted state drops by one point on every clock cycle until it reaches the slowest point. Any pending change is abandoned and every request is refused. While the over-power flag is high, a request for a faster point than the one granted is refused, and a pending change toward a faster point is abandoned. Status outputs show the last requested index, whether that request was honoured, and sticky flags for thermal and power refusals.

Top module: `pstate_arbiter`

## Requirements
- R1: After reset the granted state is `NUM_STATES-1`. Busy, honoured and both sticky refusal flags are 0. The requested-state field reads `NUM_STATES-1`, and the block treats the time since the last change as quiet.
- R2: With neither limit flag high, a request is accepted in the cycle after it is written. Busy rises, honoured clears, and the granted state stays put until the latency expires. The granted state then equals the request, busy falls and honoured is 1.
- R3: Each clock cycle with over-temperature high raises the granted index by one, saturating at `NUM_STATES-1`. Any pending change is dropped, so busy is 0 from the next cycle on.
- R4: A request written while over-temperature is high is refused. The thermal sticky flag is set, honoured is 0 and no change becomes pending.
- R5: The latency is counted in ticks from the acceptance. It is `SHORT_LAT` ticks when at least `recent_win_i` ticks have passed since the last completed change, and `LONG_LAT` ticks otherwise. The change takes effect on the clock edge of the last of those ticks.
- R6: A request accepted while a change is pending replaces the pending target. It does not restart the latency count.
- R7: A request written in the same cycle as the final latency tick replaces the target, and the new target is granted on that edge.
- R8: While over-power is high, a request whose index is lower than the granted index is refused and sets the power sticky flag. A request for the same or a larger index is accepted.
- R9: Over-power rising while a change toward a lower index is pending drops that change. It sets the power sticky flag and clears honoured, and the granted state is unchanged.
- R10: The sticky refusal flags stay set until reset.
- R11: The requested-state field shows the index of the most recent request write, whether it was accepted or refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request register write strobe |
| req_state_i | input | SW | Requested state index |
| over_temp_i | input | 1 | Over-temperature flag |
| over_power_i | input | 1 | Over-power flag |
| tick_i | input | 1 | One-cycle microsecond tick |
| recent_win_i | input | WIN_W | Quiet window in ticks |
| granted_o | output | SW | Granted state index |
| busy_o | output | 1 | Change pending |
| stat_req_o | output | SW | Last requested index |
| stat_honoured_o | output | 1 | Last request took effect |
| stat_therm_ref_o | output | 1 | Sticky thermal refusal |
| stat_pwr_ref_o | output | 1 | Sticky power refusal |

## Verification
Two events can fall in the same cycle. One is a fresh request write. The other is the final tick of a pending change, which completes that change. The bench provokes this directly: it pends a short-latency change, waits for all but one of its ticks, and then writes a new request in the same cycle as the last tick. It expects the new index to be granted on that edge with honoured set. Random stimulus produces further coincidences of requests, ticks and limit flags. A reference model steps once per clock edge from the requirements, and all outputs are compared against it every cycle.

// File: rtl/pstate_pkg.sv
package pstate_pkg;
  typedef enum logic [1:0] {
    VERD_NONE   = 2'd0,
    VERD_ACCEPT = 2'd1,
    VERD_THERM  = 2'd2,
    VERD_POWER  = 2'd3
  } verdict_e;
endpackage

// File: rtl/pst_req_filter.sv
module pst_req_filter
  import pstate_pkg::*;
#(
  parameter int NUM_STATES = 8,
  localparam int SW = $clog2(NUM_STATES)
) (
  input  logic          req_valid_i,
  input  logic [SW-1:0] req_state_i,
  input  logic          over_temp_i,
  input  logic          over_power_i,
  input  logic [SW-1:0] granted_i,
  output verdict_e      verdict_o,
  output logic [SW-1:0] target_o
);
  localparam logic [SW-1:0] LOWEST = SW'(NUM_STATES - 1);

  always_comb begin
    target_o = (req_state_i > LOWEST) ? LOWEST : req_state_i;
    if (!req_valid_i)                               verdict_o = VERD_NONE;
    else if (over_temp_i)                           verdict_o = VERD_THERM;
    else if (over_power_i && target_o < granted_i)  verdict_o = VERD_POWER;
    else                                            verdict_o = VERD_ACCEPT;
  end
endmodule

// File: rtl/pst_quiet_timer.sv
module pst_quiet_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             quiet_o
);
  localparam logic [WIN_W-1:0] SAT = '1;
  logic [WIN_W-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     since_q <= SAT;
    else if (clear_i)                since_q <= '0;
    else if (tick_i && since_q != SAT) since_q <= since_q + 1'b1;
  end

  assign quiet_o = (since_q >= win_i);

  a_r5_since_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q == SAT && !clear_i) |=> since_q == SAT);
  a_r5_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> since_q == '0);
endmodule

// File: rtl/pst_countdown.sv
module pst_countdown #(
  parameter int LONG_LAT  = 500,
  parameter int SHORT_LAT = 10,
  localparam int LW = $clog2(LONG_LAT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic quiet_i,
  input  logic tick_i,
  input  logic abort_i,
  output logic busy_o,
  output logic last_o
);
  logic [LW-1:0] cnt_q;
  logic          busy_q;

  assign last_o = busy_q && tick_i && (cnt_q == LW'(1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i || last_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= quiet_i ? LW'(SHORT_LAT) : LW'(LONG_LAT);
    end else if (busy_q && tick_i) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  a_r6_count_never_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !abort_i && !last_o) |=> (busy_q && cnt_q <= $past(cnt_q)));
  a_r5_busy_has_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q != '0);
endmodule

// File: rtl/pstate_arbiter.sv
module pstate_arbiter
  import pstate_pkg::*;
#(
  parameter int NUM_STATES = 8,
  parameter int WIN_W      = 16,
  parameter int LONG_LAT   = 500,
  parameter int SHORT_LAT  = 10,
  localparam int SW = $clog2(NUM_STATES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [SW-1:0]    req_state_i,
  input  logic             over_temp_i,
  input  logic             over_power_i,
  input  logic             tick_i,
  input  logic [WIN_W-1:0] recent_win_i,
  output logic [SW-1:0]    granted_o,
  output logic             busy_o,
  output logic [SW-1:0]    stat_req_o,
  output logic             stat_honoured_o,
  output logic             stat_therm_ref_o,
  output logic             stat_pwr_ref_o
);
  localparam logic [SW-1:0] LOWEST = SW'(NUM_STATES - 1);

  logic [SW-1:0] granted_q, target_q, stat_req_q, req_tgt, next_tgt;
  logic          hon_q, therm_q, pwr_q;
  logic          busy, last, quiet, accept, refused, drop_pwr, abort, done;
  verdict_e      verdict;

  pst_req_filter #(.NUM_STATES(NUM_STATES)) u_filter (
    .req_valid_i (req_valid_i),
    .req_state_i (req_state_i),
    .over_temp_i (over_temp_i),
    .over_power_i(over_power_i),
    .granted_i   (granted_q),
    .verdict_o   (verdict),
    .target_o    (req_tgt)
  );

  pst_quiet_timer #(.WIN_W(WIN_W)) u_quiet (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clear_i(done),
    .win_i  (recent_win_i),
    .quiet_o(quiet)
  );

  assign accept   = (verdict == VERD_ACCEPT);
  assign refused  = (verdict == VERD_THERM) || (verdict == VERD_POWER);
  assign next_tgt = accept ? req_tgt : target_q;
  assign drop_pwr = over_power_i && !over_temp_i && busy && (next_tgt < granted_q);
  assign abort    = over_temp_i || drop_pwr;
  assign done     = last && !abort;

  pst_countdown #(.LONG_LAT(LONG_LAT), .SHORT_LAT(SHORT_LAT)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept && !busy),
    .quiet_i(quiet),
    .tick_i (tick_i),
    .abort_i(abort),
    .busy_o (busy),
    .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      granted_q  <= LOWEST;
      target_q   <= LOWEST;
      stat_req_q <= LOWEST;
      hon_q      <= 1'b0;
      therm_q    <= 1'b0;
      pwr_q      <= 1'b0;
    end else begin
      if (over_temp_i)      granted_q <= (granted_q == LOWEST) ? LOWEST : granted_q + 1'b1;
      else if (done)        granted_q <= next_tgt;
      if (accept)           target_q  <= req_tgt;
      if (req_valid_i)      stat_req_q <= req_state_i;
      if (refused || abort) hon_q <= 1'b0;
      else if (done)        hon_q <= 1'b1;
      else if (accept)      hon_q <= 1'b0;
      if (verdict == VERD_THERM)             therm_q <= 1'b1;
      if (verdict == VERD_POWER || drop_pwr) pwr_q   <= 1'b1;
    end
  end

  assign granted_o        = granted_q;
  assign busy_o           = busy;
  assign stat_req_o       = stat_req_q;
  assign stat_honoured_o  = hon_q;
  assign stat_therm_ref_o = therm_q;
  assign stat_pwr_ref_o   = pwr_q;

  a_r3_thermal_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_temp_i && granted_q != LOWEST) |=> granted_q == $past(granted_q) + 1'b1);
  a_r3_thermal_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_temp_i |=> !busy_o);
  a_r8_power_no_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_power_i |=> granted_q >= $past(granted_q));
  a_r2_grant_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(granted_q) |-> ($past(over_temp_i) || $past(busy)));
  a_r10_therm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_q |=> therm_q);
  a_r10_pwr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_q |=> pwr_q);
endmodule

// File: tb/tb_pstate_arbiter.sv
module tb_pstate_arbiter;
  localparam int NS = 8, WW = 16, LL = 500, SL = 10;
  localparam int SW = $clog2(NS);
  localparam int LOW = NS - 1;

  logic clk = 0, rst_n = 0;
  logic req_v = 0, temp = 0, pwr = 0, tick = 0;
  logic [SW-1:0] req_s = '0;
  logic [WW-1:0] win = 16'd100;
  logic [SW-1:0] granted, st_req;
  logic busy, hon, th, pw;

  int checks = 0, errors = 0;
  bit comparing = 0;

  // reference model
  int m_g, m_tgt, m_req, m_cnt, m_since;
  bit m_busy, m_hon, m_th, m_pw;

  always #2.5 clk = ~clk;

  pstate_arbiter #(.NUM_STATES(NS), .WIN_W(WW), .LONG_LAT(LL), .SHORT_LAT(SL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_state_i(req_s),
    .over_temp_i(temp), .over_power_i(pwr), .tick_i(tick), .recent_win_i(win),
    .granted_o(granted), .busy_o(busy), .stat_req_o(st_req),
    .stat_honoured_o(hon), .stat_therm_ref_o(th), .stat_pwr_ref_o(pw));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_g = LOW; m_tgt = LOW; m_req = LOW; m_cnt = 0; m_since = 65535;
      m_busy = 0; m_hon = 0; m_th = 0; m_pw = 0;
    end else begin
      int r, nt;
      bit acc, ref_t, ref_p, drop, ab, last, done, quiet;
      r = int'(req_s);
      ref_t = req_v && temp;
      ref_p = req_v && !temp && pwr && (r < m_g);
      acc   = req_v && !ref_t && !ref_p;
      nt    = acc ? r : m_tgt;
      drop  = pwr && !temp && m_busy && (nt < m_g);
      ab    = temp || drop;
      last  = m_busy && tick && (m_cnt == 1);
      done  = last && !ab;
      quiet = (m_since >= int'(win));
      if (temp) m_g = (m_g == LOW) ? LOW : m_g + 1;
      else if (done) m_g = nt;
      if (acc) m_tgt = r;
      if (req_v) m_req = r;
      if (ref_t || ref_p || ab) m_hon = 0;
      else if (done) m_hon = 1;
      else if (acc) m_hon = 0;
      if (ref_t) m_th = 1;
      if (ref_p || drop) m_pw = 1;
      if (ab || last) begin m_busy = 0; m_cnt = 0; end
      else if (acc && !m_busy) begin m_busy = 1; m_cnt = quiet ? SL : LL; end
      else if (m_busy && tick) m_cnt = m_cnt - 1;
      if (done) m_since = 0;
      else if (tick && m_since != 65535) m_since = m_since + 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (comparing && rst_n) begin
      chk("R2 R3 granted vs model", int'(granted), m_g);
      chk("R5 R6 busy vs model", int'(busy), int'(m_busy));
      chk("R2 honoured vs model", int'(hon), int'(m_hon));
      chk("R4 thermal flag vs model", int'(th), int'(m_th));
      chk("R8 R9 power flag vs model", int'(pw), int'(m_pw));
      chk("R11 requested vs model", int'(st_req), m_req);
    end
  end

  // one cycle of stimulus, driven and released on falling edges
  task automatic step(bit v, int s, bit t);
    req_v = v; req_s = SW'(s); tick = t;
    @(negedge clk);
    req_v = 0; tick = 0;
  endtask
  task automatic ticks(int n);
    repeat (n) step(0, 0, 1);
  endtask
  task automatic idle(int n);
    repeat (n) step(0, 0, 0);
  endtask
  task automatic do_reset();
    rst_n = 0; temp = 0; pwr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1
    chk("R1 granted", granted, LOW);
    chk("R1 busy", busy, 0);
    chk("R1 honoured", hon, 0);
    chk("R1 sticky", th | pw, 0);
    chk("R1 requested", st_req, LOW);

    // R2 R5: quiet after reset -> short latency
    step(1, 2, 0);
    chk("R2 busy after accept", busy, 1);
    chk("R11 requested", st_req, 2);
    ticks(SL - 1);
    chk("R5 not yet granted", granted, LOW);
    ticks(1);
    chk("R2 granted", granted, 2);
    chk("R2 busy clear", busy, 0);
    chk("R2 honoured", hon, 1);

    // R5: immediately after a change -> long latency
    step(1, 1, 0);
    ticks(LL - 1);
    chk("R5 long pending", busy, 1);
    chk("R5 long not granted", granted, 2);
    ticks(1);
    chk("R5 long granted", granted, 1);

    // R5 boundary: window-1 ticks is still recent
    ticks(99);
    step(1, 0, 0);
    ticks(SL);
    chk("R5 window-1 is long", busy, 1);
    ticks(LL - SL);
    chk("R5 window-1 done", granted, 0);
    ticks(100);
    step(1, 4, 0);
    ticks(SL - 1);
    chk("R5 window exact still busy", busy, 1);
    ticks(1);
    chk("R5 window exact is short", granted, 4);

    // R6 replacement without restart
    ticks(100);
    step(1, 3, 0);
    ticks(4);
    step(1, 5, 0);
    chk("R6 still busy", busy, 1);
    ticks(SL - 5);
    chk("R6 not early", granted, 4);
    ticks(1);
    chk("R6 replaced target", granted, 5);
    chk("R11 requested", st_req, 5);

    // R7 request on the final tick
    ticks(100);
    step(1, 6, 0);
    ticks(SL - 1);
    step(1, 1, 1);
    chk("R7 new target granted", granted, 1);
    chk("R7 busy clear", busy, 0);
    chk("R7 honoured", hon, 1);

    // R8 power refusal and acceptance
    ticks(100);
    pwr = 1;
    step(1, 0, 0);
    chk("R8 refused busy", busy, 0);
    chk("R8 power flag", pw, 1);
    chk("R8 honoured clear", hon, 0);
    chk("R11 refused requested", st_req, 0);
    chk("R8 granted unchanged", granted, 1);
    step(1, 3, 0);
    chk("R8 lower point accepted", busy, 1);
    ticks(SL);
    chk("R8 lower point granted", granted, 3);
    pwr = 0;
    idle(3);
    chk("R10 power flag held", pw, 1);

    // R9 power drops pending raise
    do_reset();
    step(1, 0, 0);
    ticks(3);
    pwr = 1;
    idle(1);
    chk("R9 dropped", busy, 0);
    chk("R9 flag", pw, 1);
    chk("R9 honoured", hon, 0);
    pwr = 0;
    ticks(SL);
    chk("R9 granted unchanged", granted, LOW);

    // R3 R4 thermal
    do_reset();
    step(1, 0, 0);
    ticks(SL);
    chk("R2 at top", granted, 0);
    step(1, 2, 0);
    temp = 1;
    idle(1);
    chk("R3 first step", granted, 1);
    chk("R3 pending dropped", busy, 0);
    idle(1);
    chk("R3 second step", granted, 2);
    step(1, 0, 0);
    chk("R4 refused flag", th, 1);
    chk("R4 honoured", hon, 0);
    chk("R4 no pending", busy, 0);
    chk("R3 third step", granted, 3);
    idle(4);
    chk("R3 at lowest", granted, LOW);
    idle(1);
    chk("R3 saturates", granted, LOW);
    temp = 0;
    ticks(20);
    chk("R4 nothing granted later", granted, LOW);
    chk("R10 thermal flag held", th, 1);

    // random phase against model
    do_reset();
    win = 16'd40;
    comparing = 1;
    for (int i = 0; i < 40000; i++) begin
      int rv;
      rv = $urandom_range(0, 999);
      if (rv < 3) temp = ~temp;
      else if (rv < 8) pwr = ~pwr;
      if (temp && $urandom_range(0, 9) == 0) temp = 0;
      step($urandom_range(0, 149) == 0, $urandom_range(0, NS - 1), $urandom_range(0, 1));
    end
    comparing = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule